// File: doc/BRIEF.md
# Register-Indirect Address Generator with Pointer Update

This block produces the data-bus addresses for a memory reference whose address comes from one of eight 16-bit pointer registers, and returns the value to write back into that register. Each register index has its own update rule. Indices 0 to 3 leave the pointer as it is. Indices 4, 5 and 7 step it up after each access, with index 7 being the program counter when it fetches an immediate operand. Index 6 acts as an upward-growing stack: it increments after a write and decrements before a read.

A one-shot double-byte prefix arms a mode that applies to the next accepted request only. In that mode the block issues two bus reads and packs the low byte of each read into a single word. A direct-address reference or a stack reference in that mode is refused, and the block reports this on an illegal-mode output.

The register file, the instruction decoder and bus timing beyond a simple request/acknowledge exchange lie outside the block. A request is accepted only while the block is idle. The block then issues one or two bus accesses, each held until it is acknowledged, and finishes with a one-cycle completion pulse. That pulse carries the write-back value and, for a read, the assembled data.

Top module: `ptr_agen`

## Requirements
- R1: With pointer index 0, 1, 2 or 3, a single access is issued at exactly the pointer value and wb_en_o stays low at completion.
- R2: With pointer index 4, 5 or 7, a single access is issued at the pointer value and completion returns wb_en_o high with wb_val_o equal to the pointer plus one, for reads and for writes.
- R3: With pointer index 6, a write is issued at the pointer value with write-back pointer plus one. A read is issued at the pointer minus one with write-back pointer minus one.
- R4: A pulse on prefix_i sets dbl_o. The next request accepted uses double-byte mode and clears dbl_o, so the request after it is a normal single access.
- R5: In double-byte mode with index 0 to 3, two reads are issued at the same pointer address and wb_en_o stays low.
- R6: In double-byte mode with index 4, 5 or 7, reads are issued at the pointer and the pointer plus one, and wb_val_o is the pointer plus two.
- R7: A single read returns bus_rdata_i unchanged on rd_word_o. A double-byte read places bits 7:0 of the first read in rd_word_o bits 7:0 and bits 7:0 of the second read in bits 15:8. rd_vld_o is high only at the completion of a legal read.
- R8: A double-byte request with index 6 or with dir_i high completes one cycle after acceptance with illegal_o and done_o high. It issues no bus access and asserts no write-back, and it still consumes the prefix.
- R9: With dir_i high and no prefix, a single access is issued at ptr_i and wb_en_o stays low, whatever the index.
- R10: Increment and decrement wrap modulo 2^16 (FFFF+1 = 0000, 0000-1 = FFFF) with no other effect.
- R11: bus_req_o, bus_addr_o and bus_we_o hold steady until bus_ack_i, and bus_we_o follows the request's wr_i.
- R12: req_i is ignored while busy_o is high: no second operation is queued or completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prefix_i | input | 1 | Arms double-byte mode for the next request |
| req_i | input | 1 | Request strobe, taken while idle |
| idx_i | input | 3 | Pointer register index |
| wr_i | input | 1 | 1 = write access, 0 = read |
| dir_i | input | 1 | Direct addressing: ptr_i holds the address, no update |
| ptr_i | input | AW | Current pointer register value |
| busy_o | output | 1 | An operation is in progress |
| dbl_o | output | 1 | Double-byte mode armed |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Bus access is a write |
| bus_addr_o | output | AW | Bus address |
| bus_ack_i | input | 1 | Bus access accepted and read data valid |
| bus_rdata_i | input | DW | Bus read data |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Completion refused double-byte use |
| wb_en_o | output | 1 | Pointer write-back enable (valid with done_o) |
| wb_val_o | output | AW | Pointer write-back value |
| rd_vld_o | output | 1 | rd_word_o valid (with done_o) |
| rd_word_o | output | DW | Read result, single word or packed bytes |

## Verification
The bench builds the block with AW = 16 and DW = 16, which gives byte lanes of 8 bits and makes the FFFF/0000 wrap points reachable with a single pointer value. Each of the three update rules is run at and away from the wrap boundary, in both access directions. The bus responder inserts a configurable number of wait cycles. This exposes the address hold before acknowledge, the second beat of a double-byte read, and request strobes issued while busy.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;
  localparam int REG_IW = 3;
  localparam logic [REG_IW-1:0] STACK_IDX = 3'd6;

  typedef enum logic [1:0] {UPD_NONE, UPD_INC, UPD_PUSH, UPD_POP} upd_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC1, ST_ACC2, ST_DONE} st_e;

  function automatic upd_e rule_of(input logic [REG_IW-1:0] idx, input logic wr);
    upd_e r;
    case (idx)
      3'd4, 3'd5, 3'd7: r = UPD_INC;
      3'd6:             r = wr ? UPD_PUSH : UPD_POP;
      default:          r = UPD_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ptr_rule_dec.sv
module ptr_rule_dec
  import ptr_agen_pkg::*;
(
  input  logic [REG_IW-1:0] idx_i,
  input  logic              wr_i,
  input  logic              dir_i,
  input  logic              dbl_i,
  output upd_e              upd_o,
  output logic              two_beat_o,
  output logic              illegal_o
);
  always_comb begin
    illegal_o  = dbl_i & (dir_i | (idx_i == STACK_IDX));
    upd_o      = dir_i ? UPD_NONE : rule_of(idx_i, wr_i);
    two_beat_o = dbl_i & ~illegal_o;
  end
endmodule

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
  import ptr_agen_pkg::*;
#(
  parameter int AW = 16
) (
  input  upd_e          upd_i,
  input  logic          dbl_i,
  input  logic          beat_i,
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] wb_val_o,
  output logic          wb_en_o
);
  always_comb begin
    addr_o   = ptr_i;
    wb_val_o = ptr_i;
    wb_en_o  = 1'b0;
    case (upd_i)
      UPD_INC: begin
        addr_o   = ptr_i + AW'(beat_i);
        wb_val_o = ptr_i + (dbl_i ? AW'(2) : AW'(1));
        wb_en_o  = 1'b1;
      end
      UPD_PUSH: begin
        wb_val_o = ptr_i + AW'(1);
        wb_en_o  = 1'b1;
      end
      UPD_POP: begin
        addr_o   = ptr_i - AW'(1);
        wb_val_o = ptr_i - AW'(1);
        wb_en_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_pack.sv
module byte_pack #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          dbl_i,
  input  logic          beat_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] word_o
);
  localparam int BW    = DW / 2;
  localparam int LANES = 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BW-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= '0;
      end else if (cap_i) begin
        if (!dbl_i)                lane_q <= din_i[g*BW +: BW];
        else if (beat_i == 1'(g))  lane_q <= din_i[BW-1:0];
      end
    end
    assign word_o[g*BW +: BW] = lane_q;
  end
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
  import ptr_agen_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prefix_i,
  input  logic          req_i,
  input  logic [2:0]    idx_i,
  input  logic          wr_i,
  input  logic          dir_i,
  input  logic [AW-1:0] ptr_i,
  output logic          busy_o,
  output logic          dbl_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          done_o,
  output logic          illegal_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o,
  output logic          rd_vld_o,
  output logic [DW-1:0] rd_word_o
);
  st_e           st_q;
  upd_e          upd_q;
  logic          dbl_q, wr_q, ill_q, beat_q, armed_q;
  logic [AW-1:0] ptr_q;

  upd_e          dec_upd;
  logic          dec_two, dec_ill, accept, beat_ack;
  logic [AW-1:0] calc_addr, calc_wb;
  logic          calc_wb_en;

  assign accept   = req_i & (st_q == ST_IDLE);
  assign beat_ack = bus_req_o & bus_ack_i;

  ptr_rule_dec u_dec (
    .idx_i     (idx_i),
    .wr_i      (wr_i),
    .dir_i     (dir_i),
    .dbl_i     (armed_q),
    .upd_o     (dec_upd),
    .two_beat_o(dec_two),
    .illegal_o (dec_ill)
  );

  ptr_addr_calc #(.AW(AW)) u_calc (
    .upd_i   (upd_q),
    .dbl_i   (dbl_q),
    .beat_i  (beat_q),
    .ptr_i   (ptr_q),
    .addr_o  (calc_addr),
    .wb_val_o(calc_wb),
    .wb_en_o (calc_wb_en)
  );

  byte_pack #(.DW(DW)) u_pack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (beat_ack),
    .dbl_i (dbl_q),
    .beat_i(beat_q),
    .din_i (bus_rdata_i),
    .word_o(rd_word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (prefix_i) begin
      armed_q <= 1'b1;
    end else if (accept) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      upd_q  <= UPD_NONE;
      dbl_q  <= 1'b0;
      wr_q   <= 1'b0;
      ill_q  <= 1'b0;
      beat_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          upd_q  <= dec_upd;
          dbl_q  <= dec_two;
          wr_q   <= wr_i;
          ill_q  <= dec_ill;
          ptr_q  <= ptr_i;
          beat_q <= 1'b0;
          st_q   <= dec_ill ? ST_DONE : ST_ACC1;
        end
        ST_ACC1: if (bus_ack_i) begin
          if (dbl_q) begin
            beat_q <= 1'b1;
            st_q   <= ST_ACC2;
          end else begin
            st_q   <= ST_DONE;
          end
        end
        ST_ACC2: if (bus_ack_i) st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o     = (st_q != ST_IDLE);
    dbl_o      = armed_q;
    bus_req_o  = (st_q == ST_ACC1) | (st_q == ST_ACC2);
    bus_we_o   = bus_req_o & wr_q;
    bus_addr_o = calc_addr;
    done_o     = (st_q == ST_DONE);
    illegal_o  = done_o & ill_q;
    wb_en_o    = done_o & ~ill_q & calc_wb_en;
    wb_val_o   = calc_wb;
    rd_vld_o   = done_o & ~ill_q & ~wr_q;
  end
endmodule

// File: rtl/ptr_agen_chk.sv
module ptr_agen_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          prefix_i,
  input logic          req_i,
  input logic [2:0]    idx_i,
  input logic          wr_i,
  input logic          dir_i,
  input logic [AW-1:0] ptr_i,
  input logic          busy_o,
  input logic          dbl_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_ack_i,
  input logic          done_o,
  input logic          illegal_o,
  input logic          wb_en_o,
  input logic          rd_vld_o
);
  assert_plain_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && !dbl_o && !dir_i && (idx_i < 3'd4)
      |=> bus_req_o && (bus_addr_o == $past(ptr_i)));

  assert_pop_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && !dbl_o && !dir_i && (idx_i == 3'd6) && !wr_i
      |=> bus_req_o && (bus_addr_o == $past(ptr_i) - AW'(1)));

  assert_prefix_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && !prefix_i |=> !dbl_o);

  assert_refuse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && dbl_o && (dir_i || idx_i == 3'd6)
      |=> done_o && illegal_o && !bus_req_o);

  assert_refuse_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o && !wb_en_o && !rd_vld_o);

  assert_direct_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && !dbl_o && dir_i |=> bus_req_o && (bus_addr_o == $past(ptr_i)));

  assert_bus_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));

  assert_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o && !done_o);

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

bind ptr_agen ptr_agen_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prefix_i  (prefix_i),
  .req_i     (req_i),
  .idx_i     (idx_i),
  .wr_i      (wr_i),
  .dir_i     (dir_i),
  .ptr_i     (ptr_i),
  .busy_o    (busy_o),
  .dbl_o     (dbl_o),
  .bus_req_o (bus_req_o),
  .bus_we_o  (bus_we_o),
  .bus_addr_o(bus_addr_o),
  .bus_ack_i (bus_ack_i),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .wb_en_o   (wb_en_o),
  .rd_vld_o  (rd_vld_o)
);

// File: tb/ptr_agen_test.sv
`timescale 1ns/1ps
module ptr_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prefix = 1'b0, req = 1'b0, wr = 1'b0, dir = 1'b0;
  logic [2:0]  idx = '0;
  logic [15:0] ptr = '0;
  logic        busy, dbl, bus_req, bus_we, done, ill, wb_en, rd_vld;
  logic [15:0] bus_addr, wb_val, rd_word;
  logic        ack = 1'b0;
  logic [15:0] rdata = '0;

  int checks = 0, errors = 0;
  int wait_cfg = 0, wcnt = 0, n_acc = 0, hold_err = 0;
  logic [15:0] log_addr [4];
  logic [15:0] log_dat  [4];
  logic        log_we   [4];
  logic [15:0] cur_addr = '0, first_addr = '0;
  logic        cur_we = 1'b0;
  logic        r_wb_en, r_rd_vld, r_ill, r_dbl_before, r_dbl_after;
  logic [15:0] r_wb, r_word;

  always #4 clk = ~clk;

  ptr_agen uut (
    .clk_i(clk), .rst_ni(rst_n), .prefix_i(prefix), .req_i(req), .idx_i(idx),
    .wr_i(wr), .dir_i(dir), .ptr_i(ptr), .busy_o(busy), .dbl_o(dbl),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_ack_i(ack), .bus_rdata_i(rdata), .done_o(done), .illegal_o(ill),
    .wb_en_o(wb_en), .wb_val_o(wb_val), .rd_vld_o(rd_vld), .rd_word_o(rd_word)
  );

  // bus responder: ack after wait_cfg cycles, logs every accepted beat
  always @(negedge clk) begin
    if (ack) begin
      if (n_acc < 4) begin
        log_addr[n_acc] = cur_addr;
        log_dat[n_acc]  = rdata;
        log_we[n_acc]   = cur_we;
      end
      n_acc = n_acc + 1;
      wcnt  = 0;
      ack   = 1'b0;
    end
    if (bus_req) begin
      if (wcnt == 0) first_addr = bus_addr;
      else if (bus_addr != first_addr) hold_err = hold_err + 1;
      if (wcnt >= wait_cfg) begin
        ack      = 1'b1;
        cur_addr = bus_addr;
        cur_we   = bus_we;
        rdata    = {8'hA0 + 8'(n_acc), 8'h30 + 8'(n_acc)};
      end else begin
        wcnt = wcnt + 1;
      end
    end else begin
      wcnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit pre, input logic [2:0] i, input bit w, input bit d,
                        input logic [15:0] p, input bit poke);
    @(negedge clk);
    if (pre) begin
      prefix = 1'b1;
      @(negedge clk);
      prefix = 1'b0;
    end
    r_dbl_before = dbl;
    n_acc = 0;
    req = 1'b1; idx = i; wr = w; dir = d; ptr = p;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      req = 1'b1; idx = 3'd4; ptr = 16'h7777; wr = 1'b0; dir = 1'b0;
      @(negedge clk);
      req = 1'b0;
    end
    for (int k = 0; k < 60; k++) begin
      if (done) break;
      @(negedge clk);
    end
    r_wb_en = wb_en; r_wb = wb_val; r_rd_vld = rd_vld; r_word = rd_word; r_ill = ill;
    chk("done pulse", done, 1'b1);
    #1;
    r_dbl_after = dbl;
  endtask

  task automatic t_reset;
    chk("reset busy", busy, 1'b0);
    chk("reset bus_req", bus_req, 1'b0);
    chk("reset done", done, 1'b0);
    chk("R4 reset dbl", dbl, 1'b0);
  endtask

  task automatic t_plain;
    run_op(0, 3'd2, 0, 0, 16'h1234, 0);
    chk("R1 count", n_acc, 1);
    chk("R1 addr", log_addr[0], 16'h1234);
    chk("R1 no wb", r_wb_en, 1'b0);
    chk("R7 single word", r_word, log_dat[0]);
    chk("R7 rd_vld", r_rd_vld, 1'b1);
    run_op(0, 3'd3, 1, 0, 16'h4000, 0);
    chk("R1 write addr", log_addr[0], 16'h4000);
    chk("R11 we", log_we[0], 1'b1);
    chk("R1 write no wb", r_wb_en, 1'b0);
    chk("R7 no rd_vld on write", r_rd_vld, 1'b0);
  endtask

  task automatic t_postinc;
    run_op(0, 3'd4, 0, 0, 16'h0100, 0);
    chk("R2 addr", log_addr[0], 16'h0100);
    chk("R2 wb_en", r_wb_en, 1'b1);
    chk("R2 wb", r_wb, 16'h0101);
    run_op(0, 3'd5, 1, 0, 16'hFFFF, 0);
    chk("R2 write addr", log_addr[0], 16'hFFFF);
    chk("R10 wb wrap", r_wb, 16'h0000);
    run_op(0, 3'd7, 0, 0, 16'h0200, 0);
    chk("R2 pc wb", r_wb, 16'h0201);
  endtask

  task automatic t_stack;
    run_op(0, 3'd6, 1, 0, 16'h0300, 0);
    chk("R3 push addr", log_addr[0], 16'h0300);
    chk("R3 push wb", r_wb, 16'h0301);
    run_op(0, 3'd6, 0, 0, 16'h0000, 0);
    chk("R3 pop addr wrap R10", log_addr[0], 16'hFFFF);
    chk("R3 pop wb", r_wb, 16'hFFFF);
    chk("R3 pop wb_en", r_wb_en, 1'b1);
  endtask

  task automatic t_double;
    wait_cfg = 2;
    run_op(1, 3'd1, 0, 0, 16'h0500, 0);
    chk("R4 armed", r_dbl_before, 1'b1);
    chk("R4 cleared", r_dbl_after, 1'b0);
    chk("R5 count", n_acc, 2);
    chk("R5 addr0", log_addr[0], 16'h0500);
    chk("R5 addr1", log_addr[1], 16'h0500);
    chk("R5 no wb", r_wb_en, 1'b0);
    chk("R7 pack", r_word, {log_dat[1][7:0], log_dat[0][7:0]});
    run_op(1, 3'd4, 0, 0, 16'hFFFF, 0);
    chk("R6 addr0", log_addr[0], 16'hFFFF);
    chk("R6 addr1 R10", log_addr[1], 16'h0000);
    chk("R6 wb", r_wb, 16'h0001);
    chk("R7 pack2", r_word, {log_dat[1][7:0], log_dat[0][7:0]});
    wait_cfg = 0;
    run_op(1, 3'd7, 0, 0, 16'h0800, 0);
    chk("R6 pc addr1", log_addr[1], 16'h0801);
    chk("R6 pc wb", r_wb, 16'h0802);
    run_op(0, 3'd4, 0, 0, 16'h0900, 0);
    chk("R4 one-shot count", n_acc, 1);
    chk("R4 one-shot wb", r_wb, 16'h0901);
  endtask

  task automatic t_illegal;
    run_op(1, 3'd6, 0, 0, 16'h0A00, 0);
    chk("R8 stack illegal", r_ill, 1'b1);
    chk("R8 no access", n_acc, 0);
    chk("R8 no wb", r_wb_en, 1'b0);
    chk("R8 prefix consumed", r_dbl_after, 1'b0);
    run_op(1, 3'd5, 0, 1, 16'h0B00, 0);
    chk("R8 direct illegal", r_ill, 1'b1);
    chk("R8 direct no access", n_acc, 0);
  endtask

  task automatic t_direct;
    run_op(0, 3'd4, 0, 1, 16'h00A0, 0);
    chk("R9 addr", log_addr[0], 16'h00A0);
    chk("R9 no wb", r_wb_en, 1'b0);
    chk("R9 legal", r_ill, 1'b0);
  endtask

  task automatic t_busy;
    int extra;
    wait_cfg = 3;
    hold_err = 0;
    run_op(0, 3'd2, 0, 0, 16'h0C00, 1);
    chk("R12 count", n_acc, 1);
    chk("R12 addr", log_addr[0], 16'h0C00);
    extra = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done || bus_req) extra++;
    end
    chk("R12 nothing queued", extra, 0);
    chk("R11 address held", hold_err, 0);
    wait_cfg = 0;
  endtask

  initial begin
    #100000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_postinc();
    t_stack();
    t_double();
    t_illegal();
    t_direct();
    t_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule